// File: doc/BRIEF.md
# Trigger Timestamp Queue

This block stamps external events with the current time. Each of two trigger inputs is resynchronised, watched for one chosen edge, and on that edge the 64-bit time value supplied by the surrounding timer is written into a 16-entry queue that belongs to that input. Software drains a queue through two 32-bit registers: it reads the low half first, then the high half, and the high read retires the entry.

Event flags report each stored stamp, a queue whose fill level reaches a programmed threshold, and a stamp lost because its queue was full. The flags are cleared by writing ones to them. A mask register selects which flags drive the single interrupt output. The time counter is outside the block and arrives on `time_i`.

The register port has no wait states. A write takes effect at the next rising clock edge. Read data is combinational from `reg_addr`, and a read that retires an entry does so at the clock edge that ends the read cycle.

Top module: `trig_stamp_queue`

## Requirements
- R1: After reset, the control, event and mask registers and the status register (word addresses 0, 1, 2 and 3) read zero, the threshold register (address 4) reads 7, and `irq_o` is low.
- R2: While polarity bit 8+i of the control register is 0, a rising edge on `trig_i[i]` stores one entry. The trigger passes two synchroniser flops, so the stored value is the `time_i` presented during the cycle that ends with the third rising clock edge after the trigger changed.
- R3: While polarity bit 8+i is 1, only a falling edge on `trig_i[i]` stores an entry, and a rising edge stores nothing.
- R4: Address 8+2i returns bits 31:0 of the oldest entry of input i and leaves it in place. Address 9+2i returns bits 63:32 of that entry and removes it. Entries leave in the order they were captured, and each input has its own queue.
- R5: Status bit 24+i is 1 while queue i holds at least one entry. Reading an empty queue returns zero in both words and changes nothing.
- R6: Each queue holds 16 entries. A capture into a full queue is dropped, leaves the stored entries untouched and sets event bit 28+i.
- R7: Every stored capture on input i sets event bit 24+i.
- R8: The threshold register (address 4, bits 4:0) is shared by both inputs. When a capture on input i brings that queue's fill level equal to a nonzero threshold, event bit 20+i is set.
- R9: Writing a one to an event bit clears it, and writing a zero leaves it alone. If a clear and a new set land in the same cycle, the set wins.
- R10: `irq_o` is high exactly when some event bit is set whose bit in the mask register (address 2) is also set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| time_i | input | 64 | Current time from the timer |
| trig_i | input | 2 | Asynchronous trigger inputs |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (read side effects) |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq_o | output | 1 | Masked interrupt request |

## Verification
A trigger change driven at a falling clock edge becomes a queue entry at the third rising edge that follows. The capture flags and the status bit move at that same edge. The bench therefore waits three falling edges after each trigger change before it relies on the entry. It predicts the stamp as the time value it drove two falling edges after the change.

Register writes and retiring reads act at the next rising edge, and `irq_o` follows one edge after the mask or event write that changes it. Every read and every interrupt sample is taken just after a falling edge, clear of the active edge.

// File: rtl/tsq_pkg.sv
package tsq_pkg;
    localparam int unsigned ADDR_W       = 4;
    localparam int unsigned DATA_W       = 32;
    localparam int unsigned STAMP_W      = 64;
    localparam int unsigned POL_BASE     = 8;
    localparam int unsigned THR_EVT_BASE = 20;
    localparam int unsigned CAP_EVT_BASE = 24;
    localparam int unsigned OVF_EVT_BASE = 28;
    localparam int unsigned VALID_BASE   = 24;

    localparam logic [ADDR_W-1:0] A_CTRL    = 4'h0;
    localparam logic [ADDR_W-1:0] A_EVENT   = 4'h1;
    localparam logic [ADDR_W-1:0] A_MASK    = 4'h2;
    localparam logic [ADDR_W-1:0] A_STATUS  = 4'h3;
    localparam logic [ADDR_W-1:0] A_THRESH  = 4'h4;
    localparam int unsigned       A_TS_BASE = 8;

    // Bits of the event register that exist for n inputs.
    function automatic logic [DATA_W-1:0] evt_mask(input int unsigned n);
        logic [DATA_W-1:0] m;
        m = '0;
        for (int unsigned k = 0; k < n; k++) begin
            m[THR_EVT_BASE + k] = 1'b1;
            m[CAP_EVT_BASE + k] = 1'b1;
            m[OVF_EVT_BASE + k] = 1'b1;
        end
        return m;
    endfunction
endpackage

// File: rtl/tsq_edge_detect.sv
module tsq_edge_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_i,
    input  logic fall_sel_i,
    output logic hit_o
);
    typedef struct packed {
        logic s1;
        logic s2;
        logic s3;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = trig_i;
        st_d.s2 = st_q.s1;
        st_d.s3 = st_q.s2;
        hit_o   = fall_sel_i ? (!st_q.s2 && st_q.s3) : (st_q.s2 && !st_q.s3);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // One synchronised edge yields a single detection cycle.
    p_one_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_o && $stable(fall_sel_i)) |=> (!hit_o || $changed(fall_sel_i)));
endmodule

// File: rtl/tsq_fifo.sv
module tsq_fifo #(
    parameter int unsigned WIDTH = 64,
    parameter int unsigned DEPTH = 16
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           push_i,
    input  logic [WIDTH-1:0]               data_i,
    input  logic                           pop_i,
    output logic [WIDTH-1:0]               head_o,
    output logic [$clog2(DEPTH+1)-1:0]     count_o,
    output logic                           full_o,
    output logic                           empty_o
);
    localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    typedef struct packed {
        logic [PW-1:0] wptr;
        logic [PW-1:0] rptr;
        logic [CW-1:0] count;
    } fifo_t;

    fifo_t f_d, f_q;
    logic [WIDTH-1:0] mem [DEPTH];
    logic do_push, do_pop;

    always_comb begin
        f_d     = f_q;
        full_o  = (f_q.count == CW'(DEPTH));
        empty_o = (f_q.count == '0);
        do_push = push_i && !full_o;
        do_pop  = pop_i && !empty_o;
        if (do_push) f_d.wptr = (f_q.wptr == LAST) ? '0 : f_q.wptr + 1'b1;
        if (do_pop)  f_d.rptr = (f_q.rptr == LAST) ? '0 : f_q.rptr + 1'b1;
        case ({do_push, do_pop})
            2'b10:   f_d.count = f_q.count + 1'b1;
            2'b01:   f_d.count = f_q.count - 1'b1;
            default: f_d.count = f_q.count;
        endcase
        head_o  = empty_o ? '0 : mem[f_q.rptr];
        count_o = f_q.count;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[f_q.wptr] <= data_i;
    end

    p_count_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        count_o <= CW'(DEPTH));
    p_full_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && full_o && !pop_i) |=> $stable(count_o));
    p_empty_pop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && empty_o && !push_i) |=> (count_o == '0));
endmodule

// File: rtl/trig_stamp_queue.sv
module trig_stamp_queue #(
    parameter int unsigned N_TRIG     = 2,
    parameter int unsigned DEPTH      = 16,
    parameter int unsigned THR_RESET  = 7
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [63:0] time_i,
    input  logic [1:0]  trig_i,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [3:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        irq_o
);
    import tsq_pkg::*;

    localparam int unsigned CNT_W = $clog2(DEPTH + 1);
    localparam logic [DATA_W-1:0] EVT_MASK = evt_mask(N_TRIG);

    typedef struct packed {
        logic [N_TRIG-1:0] pol;
        logic [DATA_W-1:0] evt;
        logic [DATA_W-1:0] mask;
        logic [CNT_W-1:0]  thr;
    } regs_t;

    regs_t r_d, r_q;

    logic [N_TRIG-1:0] hit, full, empty, push, pop;
    logic [STAMP_W-1:0] head [N_TRIG];
    logic [CNT_W-1:0]   cnt  [N_TRIG];
    logic [DATA_W-1:0]  w1c, set;

    for (genvar gi = 0; gi < N_TRIG; gi++) begin : g_in
        localparam logic [ADDR_W-1:0] HI_A = ADDR_W'(A_TS_BASE + 2*gi + 1);

        tsq_edge_detect u_edge (
            .clk        (clk),
            .rst_n      (rst_n),
            .trig_i     (trig_i[gi]),
            .fall_sel_i (r_q.pol[gi]),
            .hit_o      (hit[gi])
        );

        assign push[gi] = hit[gi] && !full[gi];
        assign pop[gi]  = reg_rd && (reg_addr == HI_A);

        tsq_fifo #(.WIDTH(STAMP_W), .DEPTH(DEPTH)) u_fifo (
            .clk     (clk),
            .rst_n   (rst_n),
            .push_i  (hit[gi]),
            .data_i  (time_i),
            .pop_i   (pop[gi]),
            .head_o  (head[gi]),
            .count_o (cnt[gi]),
            .full_o  (full[gi]),
            .empty_o (empty[gi])
        );

        p_cap_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
            push[gi] |=> r_q.evt[CAP_EVT_BASE + gi]);
        p_ovf_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (hit[gi] && full[gi]) |=> r_q.evt[OVF_EVT_BASE + gi]);
        p_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
            push[gi] |=> !empty[gi]);
    end

    // Next-state of the software-visible registers.
    always_comb begin
        r_d = r_q;
        w1c = '0;
        set = '0;
        if (reg_wr) begin
            case (reg_addr)
                A_CTRL: begin
                    for (int unsigned k = 0; k < N_TRIG; k++)
                        r_d.pol[k] = reg_wdata[POL_BASE + k];
                end
                A_EVENT:  w1c       = reg_wdata & EVT_MASK;
                A_MASK:   r_d.mask  = reg_wdata & EVT_MASK;
                A_THRESH: r_d.thr   = reg_wdata[CNT_W-1:0];
                default: ;
            endcase
        end
        for (int unsigned k = 0; k < N_TRIG; k++) begin
            if (push[k]) set[CAP_EVT_BASE + k] = 1'b1;
            if (hit[k] && full[k]) set[OVF_EVT_BASE + k] = 1'b1;
            if (push[k] && (r_q.thr != '0) &&
                (({1'b0, cnt[k]} + 1'b1) == {1'b0, r_q.thr}))
                set[THR_EVT_BASE + k] = 1'b1;
        end
        r_d.evt = (r_q.evt & ~w1c) | set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.thr  <= CNT_W'(THR_RESET);
        end else begin
            r_q <= r_d;
        end
    end

    // Read multiplexer.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_CTRL: begin
                for (int unsigned k = 0; k < N_TRIG; k++)
                    reg_rdata[POL_BASE + k] = r_q.pol[k];
            end
            A_EVENT:  reg_rdata = r_q.evt;
            A_MASK:   reg_rdata = r_q.mask;
            A_STATUS: begin
                for (int unsigned k = 0; k < N_TRIG; k++)
                    reg_rdata[VALID_BASE + k] = !empty[k];
            end
            A_THRESH: reg_rdata[CNT_W-1:0] = r_q.thr;
            default: begin
                for (int unsigned k = 0; k < N_TRIG; k++) begin
                    if (reg_addr == ADDR_W'(A_TS_BASE + 2*k))
                        reg_rdata = head[k][31:0];
                    if (reg_addr == ADDR_W'(A_TS_BASE + 2*k + 1))
                        reg_rdata = head[k][63:32];
                end
            end
        endcase
    end

    assign irq_o = |(r_q.evt & r_q.mask);

    p_irq_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.mask == '0) |-> !irq_o);
    p_evt_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_wr && (hit == '0)) |=> $stable(r_q.evt));
endmodule

// File: tb/trig_stamp_queue_tb.sv
module trig_stamp_queue_tb;
    localparam time CLK_PERIOD = 10ns;
    localparam logic [63:0] STEP = 64'h0000_0001_0000_0007;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] time_i = 64'h1234_5678_FFFF_FFF0;
    logic [1:0]  trig_i = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    bit pol_fall [2] = '{1'b0, 1'b0};
    logic [63:0] exp_q [2][$];

    always #(CLK_PERIOD/2) clk = ~clk;

    trig_stamp_queue u_dut (
        .clk(clk), .rst_n(rst_n), .time_i(time_i), .trig_i(trig_i),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        reg_wr = 1'b0;
        reg_rd = 1'b0;
        time_i = time_i + STEP;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        tick();
    endtask

    task automatic chk_reg(input logic [3:0] a, input logic [31:0] e, input string req);
        logic [31:0] v;
        rd(a, v);
        chk(v == e, req, {32'h0, v}, {32'h0, e});
    endtask

    // Driver: one pulse on input i; expected stamp goes to the scoreboard.
    task automatic record(input int i, input logic [63:0] v);
        if (exp_q[i].size() < 16) exp_q[i].push_back(v);
    endtask

    task automatic pulse(input int i);
        tick();
        trig_i[i] = 1'b1;
        if (!pol_fall[i]) record(i, time_i + 2*STEP);
        tick(); tick(); tick();
        trig_i[i] = 1'b0;
        if (pol_fall[i]) record(i, time_i + 2*STEP);
        tick(); tick(); tick();
    endtask

    // Monitor side: read low then high and compare with the scoreboard.
    task automatic pop_cmp(input int i, input string req);
        logic [31:0] lo, hi;
        logic [63:0] e;
        rd(4'(8 + 2*i), lo);
        rd(4'(9 + 2*i), hi);
        e = (exp_q[i].size() > 0) ? exp_q[i].pop_front() : 64'h0;
        chk({hi, lo} == e, req, {hi, lo}, e);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=hung expected=complete");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick();
        // R1 reset values
        chk_reg(4'h0, 32'h0, "R1 ctrl");
        chk_reg(4'h1, 32'h0, "R1 event");
        chk_reg(4'h2, 32'h0, "R1 mask");
        chk_reg(4'h3, 32'h0, "R1 status");
        chk_reg(4'h4, 32'd7, "R1 thresh");
        chk(irq_o == 1'b0, "R1 irq", {63'h0, irq_o}, 64'h0);
        pop_cmp(0, "R5 empty read");
        chk_reg(4'h3, 32'h0, "R5 empty read no effect");

        // R2 rising capture, R7 capture flag, R5 valid bit
        pulse(0);
        chk_reg(4'h3, 32'h0100_0000, "R5 valid");
        chk_reg(4'h1, 32'h0100_0000, "R7 capture flag");
        pop_cmp(0, "R2 rising stamp");
        chk_reg(4'h3, 32'h0, "R4 pop on high read");
        wr(4'h1, 32'hFFFF_FFFF);

        // R3 falling polarity on input 1
        wr(4'h0, 32'h0000_0200);
        pol_fall[1] = 1'b1;
        chk_reg(4'h0, 32'h0000_0200, "R3 ctrl readback");
        pulse(1);
        chk_reg(4'h3, 32'h0200_0000, "R3 one entry");
        pop_cmp(1, "R3 falling stamp");
        chk_reg(4'h3, 32'h0, "R3 rising edge ignored");

        // R4 ordering and independence
        pulse(0); pulse(1); pulse(0); pulse(0);
        pop_cmp(1, "R4 input1 entry");
        pop_cmp(0, "R4 order 1");
        pop_cmp(0, "R4 order 2");
        pop_cmp(0, "R4 order 3");
        chk_reg(4'h3, 32'h0, "R4 drained");
        wr(4'h1, 32'hFFFF_FFFF);

        // R8 threshold
        wr(4'h4, 32'd3);
        chk_reg(4'h4, 32'd3, "R8 thresh readback");
        pulse(0); pulse(0);
        chk_reg(4'h1, 32'h0100_0000, "R8 below threshold");
        pulse(0);
        chk_reg(4'h1, 32'h0110_0000, "R8 threshold reached");

        // R9 write-one-to-clear
        wr(4'h1, 32'h0);
        chk_reg(4'h1, 32'h0110_0000, "R9 zero write");
        wr(4'h1, 32'h0100_0000);
        chk_reg(4'h1, 32'h0010_0000, "R9 one clears");

        // R10 masking
        chk(irq_o == 1'b0, "R10 mask zero", {63'h0, irq_o}, 64'h0);
        wr(4'h2, 32'h0100_0000);
        #1 chk(irq_o == 1'b0, "R10 unmasked clear bit", {63'h0, irq_o}, 64'h0);
        wr(4'h2, 32'h0010_0000);
        #1 chk(irq_o == 1'b1, "R10 masked event", {63'h0, irq_o}, 64'h1);
        wr(4'h1, 32'h0010_0000);
        #1 chk(irq_o == 1'b0, "R10 after clear", {63'h0, irq_o}, 64'h0);
        wr(4'h2, 32'h0);
        pop_cmp(0, "R4 drain 1");
        pop_cmp(0, "R4 drain 2");
        pop_cmp(0, "R4 drain 3");
        wr(4'h1, 32'hFFFF_FFFF);

        // R6 overflow: 17 captures into a 16-deep queue
        wr(4'h4, 32'd0);
        for (int n = 0; n < 17; n++) pulse(0);
        chk_reg(4'h1, 32'h1100_0000, "R6 overflow flag");
        for (int n = 0; n < 16; n++) pop_cmp(0, "R6 kept entries");
        chk_reg(4'h3, 32'h0, "R6 extra capture dropped");
        pop_cmp(0, "R5 empty after drain");

        finish_run();
    end
endmodule